// File: doc/BRIEF.md
# Repeated-Primitive Suppressor with Alignment Insertion

This block sits on the transmit side of a serial storage link layer, just ahead of scrambling and line encoding. Upstream logic hands it one 32-bit dword per transfer, tagged as a primitive (control word) or as payload data. The block forwards that stream to the physical layer. When the same primitive keeps arriving, it sends two literal copies and then replaces every later copy with the continue primitive. This keeps the line from carrying long runs of one identical control word.

A level request input makes the block insert a pair of alignment primitives. The pair takes priority over upstream traffic, and the second word of the pair always follows the first. If suppression was active when the pair began, the block then sends the held primitive twice on its own before it emits continue words again. The receiver can therefore recover the suppressed primitive after the interruption.

Both sides use valid/ready. Upstream back-pressure is taken straight from downstream ready, with no register in between, whenever the block is forwarding. It is forced low while the block sends words of its own: the alignment pair and the replayed copies. The block does not queue any words. A forwarded word leaves in the same cycle it is accepted.

Top module: `prim_repeat_suppressor`

## Requirements
- R1: A primitive that differs from the held one, or that follows a data dword or a reset, is sent literally with out_charisk=1. The next identical primitive is also sent literally.
- R2: The third and every later consecutive identical primitive goes out as the continue word 32'h9999AA7C with out_charisk=1, while that input is still consumed.
- R3: A data dword (in_is_prim=0) is forwarded unchanged with out_charisk=0. It ends suppression, so the next primitive starts again with two literal copies.
- R4: While align_req is high, or while a pair is half sent, the output is the alignment word 32'h7B4A4ABC with out_charisk=1 and in_ready=0. Once the first word of a pair is accepted downstream, the second word follows as the next output regardless of align_req.
- R5: If suppression was active when a pair completes, the block sends the held primitive literally twice, with in_ready=0. After that, identical inputs produce continue words again. A run therefore reads P,P,CONT,CONT,ALIGN,ALIGN,P,P,CONT,CONT.
- R6: If suppression was not yet active when a pair completes, the repeat count restarts. The next primitive is sent literally twice before any continue word.
- R7: When the block is forwarding upstream words, out_valid equals in_valid and in_ready equals out_ready. A word moves only when out_valid and out_ready are both high, and a stalled output keeps its value while the inputs are held.
- R8: A synchronous reset (rst high) clears the held primitive, the repeat count, any pending pair half and any pending replay. After reset with no input valid, out_valid=0 and in_ready follows out_ready.
- R9: out_charisk is 1 for every primitive output (literal, continue, alignment, replay) and 0 only for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_req | input | 1 | Level request to insert an alignment pair |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word accepted when high with in_valid |
| in_dword | input | DW | Upstream dword |
| in_is_prim | input | 1 | Upstream dword is a primitive |
| out_valid | output | 1 | Output dword valid |
| out_ready | input | 1 | Downstream accepts the output dword |
| out_dword | output | DW | Dword toward the physical layer |
| out_charisk | output | 1 | Output dword is a control word |

## Verification
Two functions can fall in the same cycle. An alignment request can arrive while an upstream repeat would have become a continue word, or while replay copies are still pending. The random sweep provokes both by raising align_req at random during long runs of one primitive, with random downstream stalls. A reference model in the bench, written from the requirements, predicts each cycle's output word, flag and both ready/valid signals. Directed runs compare the exact word order against the sequences stated in R5 and R6.

// File: rtl/prim_sup_pkg.sv
package prim_sup_pkg;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_ALIGN  = 2'd1,
    MODE_REPLAY = 2'd2
  } tx_mode_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/prim_repeat_tracker.sv
module prim_repeat_tracker
  import prim_sup_pkg::*;
#(
  parameter int DW  = 32,
  parameter int LIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pass_fire,
  input  logic          pair_done,
  input  logic [DW-1:0] in_dword,
  input  logic          in_is_prim,
  output logic [DW-1:0] held_dword,
  output logic          sup_active,
  output logic          sup_match
);
  localparam int CW = cnt_w(LIT);
  localparam logic [CW-1:0] FULL = CW'(LIT);

  logic [CW-1:0] rep_q;
  logic [DW-1:0] held_q;
  logic          same_prim;

  assign same_prim = in_is_prim && (in_dword == held_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q  <= '0;
      held_q <= '0;
    end else if (pass_fire) begin
      if (!in_is_prim) begin
        rep_q <= '0;
      end else if (rep_q != '0 && same_prim) begin
        if (rep_q != FULL) rep_q <= rep_q + CW'(1);
      end else begin
        held_q <= in_dword;
        rep_q  <= CW'(1);
      end
    end else if (pair_done && rep_q != FULL) begin
      rep_q <= '0;
    end
  end

  assign held_dword = held_q;
  assign sup_active = (rep_q == FULL);
  assign sup_match  = sup_active && same_prim;
endmodule

// File: rtl/prim_align_sched.sv
module prim_align_sched
  import prim_sup_pkg::*;
#(
  parameter int LIT = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     align_req,
  input  logic     fire,
  input  logic     sup_active,
  output tx_mode_e mode,
  output logic     pair_done
);
  localparam int CW = cnt_w(LIT);
  localparam logic [CW-1:0] FULL = CW'(LIT);

  logic          half_q;
  logic [CW-1:0] rpl_q;

  always_comb begin
    if (half_q || align_req) mode = MODE_ALIGN;
    else if (rpl_q != '0)    mode = MODE_REPLAY;
    else                     mode = MODE_PASS;
  end

  assign pair_done = fire && half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      rpl_q  <= '0;
    end else if (fire) begin
      unique case (mode)
        MODE_ALIGN: begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            rpl_q  <= sup_active ? FULL : '0;
          end
        end
        MODE_REPLAY: rpl_q <= rpl_q - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prim_out_mux.sv
module prim_out_mux
  import prim_sup_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] ALIGN_W = 32'h7B4A_4ABC,
  parameter logic [DW-1:0] CONT_W  = 32'h9999_AA7C
) (
  input  tx_mode_e      mode,
  input  logic          in_valid,
  input  logic [DW-1:0] in_dword,
  input  logic          in_is_prim,
  input  logic          out_ready,
  input  logic [DW-1:0] held_dword,
  input  logic          sup_match,
  output logic          out_valid,
  output logic [DW-1:0] out_dword,
  output logic          out_charisk,
  output logic          in_ready
);
  always_comb begin
    out_valid   = 1'b1;
    out_dword   = ALIGN_W;
    out_charisk = 1'b1;
    in_ready    = 1'b0;
    unique case (mode)
      MODE_REPLAY: out_dword = held_dword;
      MODE_PASS: begin
        out_valid   = in_valid;
        in_ready    = out_ready;
        out_dword   = sup_match ? CONT_W : in_dword;
        out_charisk = in_is_prim;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prim_repeat_suppressor.sv
module prim_repeat_suppressor
  import prim_sup_pkg::*;
#(
  parameter int            DW      = 32,
  parameter int            LIT     = 2,
  parameter logic [DW-1:0] ALIGN_W = 32'h7B4A_4ABC,
  parameter logic [DW-1:0] CONT_W  = 32'h9999_AA7C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align_req,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dword,
  input  logic          in_is_prim,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_dword,
  output logic          out_charisk
);
  tx_mode_e      mode;
  logic          fire, pass_fire, pair_done;
  logic          sup_active, sup_match;
  logic [DW-1:0] held_dword;

  assign fire      = out_valid && out_ready;
  assign pass_fire = fire && (mode == MODE_PASS);

  prim_align_sched #(.LIT(LIT)) sched_i (
    .clk(clk), .rst(rst), .align_req(align_req), .fire(fire),
    .sup_active(sup_active), .mode(mode), .pair_done(pair_done)
  );

  prim_repeat_tracker #(.DW(DW), .LIT(LIT)) track_i (
    .clk(clk), .rst(rst), .pass_fire(pass_fire), .pair_done(pair_done),
    .in_dword(in_dword), .in_is_prim(in_is_prim), .held_dword(held_dword),
    .sup_active(sup_active), .sup_match(sup_match)
  );

  prim_out_mux #(.DW(DW), .ALIGN_W(ALIGN_W), .CONT_W(CONT_W)) mux_i (
    .mode(mode), .in_valid(in_valid), .in_dword(in_dword),
    .in_is_prim(in_is_prim), .out_ready(out_ready), .held_dword(held_dword),
    .sup_match(sup_match), .out_valid(out_valid), .out_dword(out_dword),
    .out_charisk(out_charisk), .in_ready(in_ready)
  );
endmodule

// File: rtl/prim_repeat_suppressor_chk.sv
module prim_repeat_suppressor_chk #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] ALIGN_W = 32'h7B4A_4ABC,
  parameter logic [DW-1:0] CONT_W  = 32'h9999_AA7C
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_dword,
  input logic          in_is_prim,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_dword,
  input logic          out_charisk
);
  logic is_align, is_cont, fire, al_odd, last_align;

  assign is_align = out_valid && out_charisk && (out_dword == ALIGN_W);
  assign is_cont  = out_valid && out_charisk && (out_dword == CONT_W);
  assign fire     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      al_odd     <= 1'b0;
      last_align <= 1'b0;
    end else if (fire) begin
      if (is_align) al_odd <= !al_odd;
      last_align <= is_align;
    end
  end

  // R4
  align_pair_chk: assert property (@(posedge clk) disable iff (rst)
    al_odd |-> is_align);

  // R4
  align_stall_chk: assert property (@(posedge clk) disable iff (rst)
    is_align |-> !in_ready);

  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> out_ready);

  // R5
  no_cont_after_align_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && last_align && !al_odd) |-> !is_cont);

  // R3
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_charisk) |->
      (in_valid && !in_is_prim && in_ready == out_ready && out_dword == in_dword));

  // R2
  cont_source_chk: assert property (@(posedge clk) disable iff (rst)
    is_cont |-> (in_valid && in_is_prim && in_ready == out_ready));
endmodule

bind prim_repeat_suppressor prim_repeat_suppressor_chk #(
  .DW(DW), .ALIGN_W(ALIGN_W), .CONT_W(CONT_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_dword(in_dword), .in_is_prim(in_is_prim), .out_valid(out_valid),
  .out_ready(out_ready), .out_dword(out_dword), .out_charisk(out_charisk)
);

// File: tb/prim_repeat_suppressor_tb_top.sv
module prim_repeat_suppressor_tb_top;
  localparam int          CLK_P = 10;
  localparam logic [31:0] AL = 32'h7B4A_4ABC;
  localparam logic [31:0] CT = 32'h9999_AA7C;
  localparam logic [31:0] P0 = 32'hB5B5_957C;
  localparam logic [31:0] P1 = 32'h4A4A_957C;
  localparam logic [31:0] DA = 32'h1234_5678;

  logic        clk = 1'b0, rst = 1'b1;
  logic        align_req = 1'b0, in_valid = 1'b0, in_is_prim = 1'b0, out_ready = 1'b1;
  logic [31:0] in_dword = '0;
  logic        in_ready, out_valid, out_charisk;
  logic [31:0] out_dword;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_held = '0;
  int          m_rep = 0, m_rpl = 0;
  bit          m_half = 1'b0;

  logic [31:0] fire_log [64];
  int          log_n = 0;
  logic [31:0] exp_seq [10];

  always #(CLK_P/2) clk = ~clk;

  prim_repeat_suppressor dut_i (
    .clk(clk), .rst(rst), .align_req(align_req), .in_valid(in_valid),
    .in_ready(in_ready), .in_dword(in_dword), .in_is_prim(in_is_prim),
    .out_valid(out_valid), .out_ready(out_ready), .out_dword(out_dword),
    .out_charisk(out_charisk)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input bit p, input bit ar,
                      input bit ordy, output bit acc);
    int kind;
    bit e_v, e_rdy, e_k;
    logic [31:0] e_w;
    string tag;
    @(negedge clk);
    in_valid = v; in_dword = w; in_is_prim = p; align_req = ar; out_ready = ordy;
    #(CLK_P/4);
    if (m_half || ar) kind = 1;
    else if (m_rpl > 0) kind = 2;
    else kind = 0;
    e_v = 1'b1; e_rdy = 1'b0; e_k = 1'b1; e_w = AL; tag = "R4 align word";
    if (kind == 2) begin
      e_w = m_held; tag = "R5 replay word";
    end else if (kind == 0) begin
      e_v = v; e_rdy = ordy;
      if (p && m_rep == 2 && w == m_held) begin
        e_w = CT; tag = "R2 cont word";
      end else begin
        e_w = w; e_k = p; tag = p ? "R1 literal prim" : "R3 data word";
      end
    end
    chk(out_valid == e_v, "R7 out_valid", 32'(out_valid), 32'(e_v));
    chk(in_ready == e_rdy, "R7 in_ready", 32'(in_ready), 32'(e_rdy));
    if (e_v) begin
      chk(out_dword == e_w, tag, out_dword, e_w);
      chk(out_charisk == e_k, "R9 charisk", 32'(out_charisk), 32'(e_k));
    end
    acc = v && in_ready;
    if (e_v && ordy) begin
      if (log_n < 64) fire_log[log_n] = out_dword;
      log_n++;
      if (kind == 1) begin
        if (!m_half) m_half = 1'b1;
        else begin
          m_half = 1'b0;
          if (m_rep == 2) m_rpl = 2;
          else m_rep = 0;
        end
      end else if (kind == 2) begin
        m_rpl--;
      end else if (!p) begin
        m_rep = 0;
      end else if (m_rep > 0 && w == m_held) begin
        if (m_rep < 2) m_rep++;
      end else begin
        m_held = w; m_rep = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; align_req = 1'b0; out_ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_held = '0; m_rep = 0; m_rpl = 0; m_half = 1'b0;
    #(CLK_P/4);
    chk(out_valid == 1'b0, "R8 reset out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R8 reset in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic cmp_log(input string tag, input int n);
    chk(log_n == n, {tag, " count"}, 32'(log_n), 32'(n));
    for (int i = 0; i < n; i++)
      chk(fire_log[i] == exp_seq[i], tag, fire_log[i], exp_seq[i]);
    log_n = 0;
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit acc;
    logic [31:0] lf, cur_w;
    bit cur_p;
    do_reset();

    // R5: P P C C A A P P C C
    log_n = 0;
    repeat (4) step(1, P0, 1, 0, 1, acc);
    step(1, P0, 1, 1, 1, acc);
    repeat (5) step(1, P0, 1, 0, 1, acc);
    exp_seq = '{P0, P0, CT, CT, AL, AL, P0, P0, CT, CT};
    cmp_log("R5 sequence", 10);

    // R3: data ends suppression
    step(1, DA, 0, 0, 1, acc);
    repeat (3) step(1, P0, 1, 0, 1, acc);
    exp_seq = '{DA, P0, P0, CT, 0, 0, 0, 0, 0, 0};
    cmp_log("R3 sequence", 4);

    // R6: pair before suppression restarts the count
    step(1, P1, 1, 0, 1, acc);
    step(1, P1, 1, 1, 1, acc);
    step(1, P1, 1, 0, 1, acc);
    repeat (3) step(1, P1, 1, 0, 1, acc);
    exp_seq = '{P1, AL, AL, P1, P1, CT, 0, 0, 0, 0};
    cmp_log("R6 sequence", 6);

    // R7 stall then R8 reset clears held primitive
    repeat (3) step(1, P0, 1, 0, 1, acc);
    repeat (2) step(1, P0, 1, 0, 0, acc);
    do_reset();
    log_n = 0;
    step(1, P0, 1, 0, 1, acc);
    exp_seq = '{P0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    cmp_log("R8 first prim literal", 1);

    // random sweep with concurrent align requests and stalls
    lf = 32'h1ACE_B00C;
    cur_w = P0; cur_p = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      step(lf[2:0] != 0, cur_w, cur_p, lf[7:4] == 0, lf[9:8] != 0, acc);
      if (acc) begin
        if (lf[13:11] < 4)      begin cur_w = P0; cur_p = 1'b1; end
        else if (lf[13:11] < 6) begin cur_w = P1; cur_p = 1'b1; end
        else                    begin cur_w = {lf[31:16], lf[23:8]}; cur_p = 1'b0; end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule